// File: doc/BRIEF.md
# Relocatable Page Address Generator

This block builds the 32-bit word address for a processor with 16-bit words. Zero-page and stack accesses no longer go to fixed pages. Each takes its upper sixteen address bits from its own page base register, so either region can be placed anywhere in the 4G-word space. Absolute accesses pass a full 32-bit address through unchanged.

The page bases are held in a small bank of numbered special registers. The bank sits outside the general register file and is read in parallel with it. Software reaches a special register through one exchange port. The port writes a new value into the selected register and returns the value it held before. Further special registers can be added behind new index values without any new opcodes. The block also holds the 16-bit stack pointer and updates it on each push and pull.

Top module: `reloc_page_agu`

## Requirements
- R1: With `acc_valid_i` high and access type 0 (encoding: 0 absolute, 1 zero page, 2 push, 3 pull), `addr_o` equals `abs_addr_i` in the same cycle.
- R2: A zero-page access gives `addr_o = {zero-page base, offset_i}` in the same cycle.
- R3: A push gives `addr_o = {stack base, sp_o}` in the same cycle, and SP is one lower after the clock edge. With SP at 0xFFFB, base 0 gives 0x0000FFFB and base 1 gives 0x0001FFFB.
- R4: A pull gives `addr_o = {stack base, sp_o + 1}` in the same cycle, and SP holds that incremented value after the clock edge.
- R5: SP wraps within 16 bits in both directions and never carries into the page number.
- R6: After reset the zero-page base (special index 0) is 0, the stack base (special index 1) is 1, and SP is 0xFFFF.
- R7: When `xchg_en_i` is high, `xchg_rdata_o` returns the old value of the register at `xchg_idx_i` in the same cycle, and that register takes `xchg_wdata_i` at the clock edge.
- R8: A base changed by an exchange is used from the next cycle's access onward. An access in the same cycle as the exchange uses the old base.
- R9: Special indexes 2 to 15 read as zero and ignore writes, and writes to them leave both bases unchanged.
- R10: `sp_wr_i` loads SP from `sp_wdata_i` and takes priority over a push or pull in the same cycle. SP does not change when there is no load and no push or pull.
- R11: `addr_valid_o` follows `acc_valid_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_type_i | input | 2 | 0 absolute, 1 zero page, 2 push, 3 pull |
| offset_i | input | 16 | Zero-page offset |
| abs_addr_i | input | 32 | Full address for absolute access |
| sp_wr_i | input | 1 | Load stack pointer |
| sp_wdata_i | input | 16 | Stack pointer load value |
| sp_o | output | 16 | Current stack pointer |
| xchg_en_i | input | 1 | Exchange with a special register |
| xchg_idx_i | input | 4 | Special register index |
| xchg_wdata_i | input | 16 | Value written by the exchange |
| xchg_rdata_o | output | 16 | Old value of the selected special register |
| addr_o | output | 32 | Effective word address |
| addr_valid_o | output | 1 | Address qualifier |

## Verification
The bench runs the stack pointer across 0x0000 in both directions. A design that let the increment or decrement carry into the upper half would show the page number change. It also puts an exchange and an access in the same cycle. A design that forwarded the new base would relocate that access one cycle too early. Writes to unmapped indexes must not alias onto the two real bases, and an SP load must win over a simultaneous push. Getting either wrong would move the stack or the zero page without any visible command.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned DW    = 16;
  localparam int unsigned AW    = 2 * DW;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [1:0] {
    ACC_ABS  = 2'd0,
    ACC_ZP   = 2'd1,
    ACC_PUSH = 2'd2,
    ACC_PULL = 2'd3
  } acc_e;

  localparam int unsigned ZP_IDX = 0;
  localparam int unsigned SB_IDX = 1;
endpackage

// File: rtl/pg_spec_bank.sv
module pg_spec_bank
  import pg_pkg::*;
#(
  parameter int unsigned NUM_SPEC   = 2,
  parameter logic [DW-1:0] ZP_RST   = '0,
  parameter logic [DW-1:0] SB_RST   = DW'(1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xchg_en_i,
  input  logic [IDX_W-1:0] xchg_idx_i,
  input  logic [DW-1:0]    xchg_wdata_i,
  output logic [DW-1:0]    xchg_rdata_o,
  output logic [DW-1:0]    zp_base_o,
  output logic [DW-1:0]    sb_base_o
);
  logic [NUM_SPEC-1:0][DW-1:0] regs;

  for (genvar g = 0; g < NUM_SPEC; g++) begin : g_reg
    localparam logic [DW-1:0] RST_V = (g == SB_IDX) ? SB_RST :
                                      (g == ZP_IDX) ? ZP_RST : '0;
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= RST_V;
      else if (xchg_en_i && xchg_idx_i == IDX_W'(g)) q <= xchg_wdata_i;
    end
    assign regs[g] = q;
  end

  // unmapped indexes read zero
  always_comb begin
    xchg_rdata_o = '0;
    for (int i = 0; i < NUM_SPEC; i++)
      if (xchg_idx_i == IDX_W'(i)) xchg_rdata_o = regs[i];
  end

  assign zp_base_o = regs[ZP_IDX];
  assign sb_base_o = regs[SB_IDX];
endmodule

// File: rtl/pg_stack_ptr.sv
module pg_stack_ptr
  import pg_pkg::*;
#(
  parameter logic [DW-1:0] SP_RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pull_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] ofs_o
);
  logic [DW-1:0] sp_q, sp_inc, sp_dec;

  assign sp_inc = sp_q + DW'(1);  // wraps in DW bits
  assign sp_dec = sp_q - DW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_RST;
    else if (ld_i)   sp_q <= ld_val_i;
    else if (push_i) sp_q <= sp_dec;
    else if (pull_i) sp_q <= sp_inc;
  end

  // push: post-decrement, pull: pre-increment
  assign ofs_o = pull_i ? sp_inc : sp_q;
  assign sp_o  = sp_q;
endmodule

// File: rtl/pg_addr_mux.sv
module pg_addr_mux
  import pg_pkg::*;
(
  input  acc_e          acc_type_i,
  input  logic [AW-1:0] abs_addr_i,
  input  logic [DW-1:0] offset_i,
  input  logic [DW-1:0] sp_ofs_i,
  input  logic [DW-1:0] zp_base_i,
  input  logic [DW-1:0] sb_base_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    unique case (acc_type_i)
      ACC_ZP:            addr_o = {zp_base_i, offset_i};
      ACC_PUSH, ACC_PULL: addr_o = {sb_base_i, sp_ofs_i};
      default:           addr_o = abs_addr_i;
    endcase
  end
endmodule

// File: rtl/reloc_page_agu.sv
module reloc_page_agu
  import pg_pkg::*;
#(
  parameter int unsigned NUM_SPEC = 2,
  parameter logic [DW-1:0] SP_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [1:0]       acc_type_i,
  input  logic [DW-1:0]    offset_i,
  input  logic [AW-1:0]    abs_addr_i,
  input  logic             sp_wr_i,
  input  logic [DW-1:0]    sp_wdata_i,
  output logic [DW-1:0]    sp_o,
  input  logic             xchg_en_i,
  input  logic [IDX_W-1:0] xchg_idx_i,
  input  logic [DW-1:0]    xchg_wdata_i,
  output logic [DW-1:0]    xchg_rdata_o,
  output logic [AW-1:0]    addr_o,
  output logic             addr_valid_o
);
  acc_e          acc_type;
  logic [DW-1:0] zp_base, sb_base, sp_ofs;
  logic          push, pull;

  assign acc_type = acc_e'(acc_type_i);
  assign push     = acc_valid_i && (acc_type == ACC_PUSH);
  assign pull     = acc_valid_i && (acc_type == ACC_PULL);

  pg_spec_bank #(.NUM_SPEC(NUM_SPEC)) u_bank (
    .clk_i, .rst_ni, .xchg_en_i, .xchg_idx_i, .xchg_wdata_i, .xchg_rdata_o,
    .zp_base_o(zp_base), .sb_base_o(sb_base)
  );

  pg_stack_ptr #(.SP_RST(SP_RST)) u_sp (
    .clk_i, .rst_ni, .push_i(push), .pull_i(pull),
    .ld_i(sp_wr_i), .ld_val_i(sp_wdata_i), .sp_o, .ofs_o(sp_ofs)
  );

  pg_addr_mux u_mux (
    .acc_type_i(acc_type), .abs_addr_i, .offset_i, .sp_ofs_i(sp_ofs),
    .zp_base_i(zp_base), .sb_base_i(sb_base), .addr_o
  );

  assign addr_valid_o = acc_valid_i;
endmodule

// File: rtl/pg_checker.sv
module pg_checker
  import pg_pkg::*;
#(
  parameter int unsigned NUM_SPEC = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [1:0]       acc_type_i,
  input logic [DW-1:0]    offset_i,
  input logic [AW-1:0]    abs_addr_i,
  input logic             sp_wr_i,
  input logic [DW-1:0]    sp_wdata_i,
  input logic [DW-1:0]    sp_o,
  input logic             xchg_en_i,
  input logic [IDX_W-1:0] xchg_idx_i,
  input logic [DW-1:0]    xchg_wdata_i,
  input logic [DW-1:0]    xchg_rdata_o,
  input logic [AW-1:0]    addr_o,
  input logic             addr_valid_o,
  input logic [DW-1:0]    zp_base_i,
  input logic [DW-1:0]    sb_base_i
);
  assert_abs_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_type_i == 2'd0 |-> addr_o == abs_addr_i);

  assert_zp_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_type_i == 2'd1 |-> addr_o == {zp_base_i, offset_i});

  assert_push_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_type_i == 2'd2 |-> addr_o == {sb_base_i, sp_o});

  assert_push_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_type_i == 2'd2 && !sp_wr_i |=> sp_o == $past(sp_o) - DW'(1));

  assert_pull_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_type_i == 2'd3 |-> addr_o == {sb_base_i, sp_o + DW'(1)});

  assert_pull_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_type_i == 2'd3 && !sp_wr_i |=> sp_o == $past(sp_o) + DW'(1));

  assert_xchg_zp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_en_i && xchg_idx_i == IDX_W'(ZP_IDX) |=> zp_base_i == $past(xchg_wdata_i));

  assert_xchg_sb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_en_i && xchg_idx_i == IDX_W'(SB_IDX) |=> sb_base_i == $past(xchg_wdata_i));

  assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_idx_i >= IDX_W'(NUM_SPEC) |-> xchg_rdata_o == '0);

  assert_unmapped_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xchg_en_i && xchg_idx_i < IDX_W'(NUM_SPEC)) |=> $stable(zp_base_i) && $stable(sb_base_i));

  assert_sp_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_wr_i |=> sp_o == $past(sp_wdata_i));

  assert_sp_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sp_wr_i && !(acc_valid_i && acc_type_i[1]) |=> $stable(sp_o));

  assert_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o == acc_valid_i);
endmodule

bind reloc_page_agu pg_checker #(.NUM_SPEC(NUM_SPEC)) u_chk (
  .clk_i, .rst_ni, .acc_valid_i, .acc_type_i, .offset_i, .abs_addr_i,
  .sp_wr_i, .sp_wdata_i, .sp_o, .xchg_en_i, .xchg_idx_i, .xchg_wdata_i,
  .xchg_rdata_o, .addr_o, .addr_valid_o,
  .zp_base_i(zp_base), .sb_base_i(sb_base)
);

// File: tb/reloc_page_agu_tb.sv
`timescale 1ns/1ps
module reloc_page_agu_tb;
  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0;
  logic [1:0]  acc_type = 0;
  logic [15:0] offset = 0;
  logic [31:0] abs_addr = 0;
  logic        sp_wr = 0;
  logic [15:0] sp_wdata = 0;
  logic [15:0] sp;
  logic        xchg_en = 0;
  logic [3:0]  xchg_idx = 0;
  logic [15:0] xchg_wdata = 0;
  logic [15:0] xchg_rdata;
  logic [31:0] addr;
  logic        addr_valid;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  reloc_page_agu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_type_i(acc_type),
    .offset_i(offset), .abs_addr_i(abs_addr), .sp_wr_i(sp_wr), .sp_wdata_i(sp_wdata),
    .sp_o(sp), .xchg_en_i(xchg_en), .xchg_idx_i(xchg_idx), .xchg_wdata_i(xchg_wdata),
    .xchg_rdata_o(xchg_rdata), .addr_o(addr), .addr_valid_o(addr_valid)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_type = 0; sp_wr = 0; xchg_en = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic access(logic [1:0] t, logic [15:0] ofs);
    acc_valid = 1; acc_type = t; offset = ofs; #1;
  endtask

  task automatic xchg(logic [3:0] idx, logic [15:0] wd, logic [15:0] exp_old, string req);
    xchg_en = 1; xchg_idx = idx; xchg_wdata = wd; #1;
    chk(req, {16'h0, xchg_rdata}, {16'h0, exp_old});
    step(); xchg_en = 0;
  endtask

  task automatic load_sp(logic [15:0] v);
    sp_wr = 1; sp_wdata = v; step(); sp_wr = 0;
  endtask

  task automatic t_reset();
    access(2'd1, 16'h0005);
    chk("R6 zp base", addr, 32'h0000_0005);
    access(2'd2, 16'h0);
    chk("R6 stack base/sp", addr, 32'h0001_FFFF);
    idle(); xchg_idx = 0; #1;
    chk("R6 idx0", {16'h0, xchg_rdata}, 32'h0);
    xchg_idx = 1; #1;
    chk("R6 idx1", {16'h0, xchg_rdata}, 32'h1);
    chk("R6 sp", {16'h0, sp}, 32'hFFFF);
  endtask

  task automatic t_abs();
    abs_addr = 32'hDEAD_BEEF; access(2'd0, 16'h1111);
    chk("R1 abs", addr, 32'hDEAD_BEEF);
    chk("R11 valid hi", {31'h0, addr_valid}, 32'h1);
    acc_valid = 0; #1;
    chk("R11 valid lo", {31'h0, addr_valid}, 32'h0);
    idle();
  endtask

  task automatic t_zp();
    xchg(4'd0, 16'h1234, 16'h0000, "R7 zp old");
    access(2'd1, 16'h00FF);
    chk("R2 zp byte ofs", addr, 32'h1234_00FF);
    access(2'd1, 16'hABCD);
    chk("R2 zp word ofs", addr, 32'h1234_ABCD);
    idle();
  endtask

  task automatic t_push_pull();
    load_sp(16'h0100);
    chk("R10 sp load", {16'h0, sp}, 32'h0100);
    access(2'd2, 0); chk("R3 push addr", addr, 32'h0001_0100);
    step(); chk("R3 push dec", {16'h0, sp}, 32'h00FF);
    access(2'd2, 0); chk("R3 push addr 2", addr, 32'h0001_00FF);
    step(); chk("R3 push dec 2", {16'h0, sp}, 32'h00FE);
    access(2'd3, 0); chk("R4 pull addr", addr, 32'h0001_00FF);
    step(); chk("R4 pull inc", {16'h0, sp}, 32'h00FF);
    access(2'd3, 0); chk("R4 pull addr 2", addr, 32'h0001_0100);
    step(); idle();
  endtask

  task automatic t_wrap();
    load_sp(16'h0000);
    access(2'd2, 0); chk("R5 push at 0", addr, 32'h0001_0000);
    step(); chk("R5 sp wrap down", {16'h0, sp}, 32'hFFFF);
    access(2'd3, 0); chk("R5 pull wrap addr", addr, 32'h0001_0000);
    step(); chk("R5 sp wrap up", {16'h0, sp}, 32'h0000);
    idle();
  endtask

  task automatic t_ref_push();
    load_sp(16'hFFFB);
    xchg(4'd1, 16'h0000, 16'h0001, "R7 sb old");
    access(2'd2, 0); chk("R3 push base0", addr, 32'h0000_FFFB);
    step(); idle();
    load_sp(16'hFFFB);
    xchg(4'd1, 16'h0001, 16'h0000, "R7 sb old 2");
    access(2'd2, 0); chk("R3 push base1", addr, 32'h0001_FFFB);
    step(); idle();
  endtask

  task automatic t_same_cycle();
    load_sp(16'h2000);
    xchg_en = 1; xchg_idx = 1; xchg_wdata = 16'h0007;
    access(2'd2, 0);
    chk("R8 old base used", addr, 32'h0001_2000);
    chk("R7 rdata old", {16'h0, xchg_rdata}, 32'h0001);
    step(); xchg_en = 0;
    access(2'd2, 0);
    chk("R8 new base next", addr, 32'h0007_1FFF);
    step(); idle();
    xchg(4'd1, 16'h0001, 16'h0007, "R7 restore");
  endtask

  task automatic t_unmapped();
    xchg(4'd5, 16'hBEEF, 16'h0000, "R9 idx5 reads 0");
    xchg(4'd15, 16'hCAFE, 16'h0000, "R9 idx15 reads 0");
    xchg_idx = 5; #1;
    chk("R9 idx5 kept 0", {16'h0, xchg_rdata}, 32'h0);
    xchg_idx = 0; #1;
    chk("R9 zp unchanged", {16'h0, xchg_rdata}, 32'h1234);
    xchg_idx = 1; #1;
    chk("R9 sb unchanged", {16'h0, xchg_rdata}, 32'h0001);
    access(2'd1, 16'h0042);
    chk("R9 zp addr", addr, 32'h1234_0042);
    idle();
  endtask

  task automatic t_priority();
    sp_wr = 1; sp_wdata = 16'h4000; access(2'd2, 0);
    step(); idle();
    chk("R10 load beats push", {16'h0, sp}, 32'h4000);
    step();
    chk("R10 idle hold", {16'h0, sp}, 32'h4000);
    access(2'd1, 16'h0001); step(); idle();
    chk("R10 zp no sp change", {16'h0, sp}, 32'h4000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_abs(); t_zp(); t_push_pull(); t_wrap();
        t_ref_push(); t_same_cycle(); t_unmapped(); t_priority();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule